// File: doc/BRIEF.md
# FIFO Interrupt and DMA Request Router

This block sits beside six command/result FIFO pairs and decides how each pair's service needs reach the rest of the chip. Every pair owns a flag register and a control register. The FIFO logic raises flags by pulsing set inputs. The control bits then decide whether a command FIFO fill flag or a result FIFO drain flag becomes a processor interrupt, a DMA request, or nothing at all.

A result overflow flag raises that pair's own interrupt line when its enable is set. Result overflow, command underflow and trigger overrun flags from all six pairs are also gated by their own enables and ORed into one shared error interrupt. Software clears flags by writing ones. A DMA acknowledge clears the fill or drain flag that it serves. All request outputs come from registers.

Top module: `fifo_req_router`

## Requirements
- R1: After reset, every flag and control bit is 0, every request output is 0, and every read returns 0.
- R2: Each flag register has these bits: 0 fill, 1 drain, 2 overflow, 3 underflow, 4 trigger overrun. A set pulse sets its flag. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. When a set and a clear land in the same cycle, the flag ends up set.
- R3: With the fill flag at 1 and fill enable (control bit 9) at 1, `fill_dma` is asserted when fill select (bit 8) is 1, and `fill_irq` is asserted when fill select is 0. With fill enable at 0, neither is asserted.
- R4: The drain flag follows the same routing, using drain enable (control bit 1) and drain select (control bit 0) to drive `drain_dma` and `drain_irq`.
- R5: `ovf_irq[i]` is 1 exactly when pair i's overflow flag and its overflow interrupt enable (control bit 3) are both 1.
- R6: `err_irq` is the OR, over all six pairs, of overflow AND bit 3, underflow AND bit 11, and trigger overrun AND bit 10.
- R7: Control bits 11, 10, 9, 8, 3, 1 and 0 can be written. All other control bits, and flag bits 15 to 5, read as 0. A write or read with an index of 6 or above has no effect and reads 0.
- R8: A pulse on `fill_ack[i]` or `drain_ack[i]` clears that fill or drain flag, so the request is low in the following cycle. A set pulse in the same cycle wins over the acknowledge.
- R9: Clearing a fill or drain enable or select bit while that FIFO's DMA request is asserted is illegal usage and is flagged by an assertion.
- R10: Each output is registered, and it shows the register state produced by the most recent clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_ctrl | input | 1 | 1 selects the control register, 0 the flag register |
| reg_idx | input | 3 | Pair index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| fill_set | input | 6 | Fill flag set pulses |
| drain_set | input | 6 | Drain flag set pulses |
| ovf_set | input | 6 | Result overflow set pulses |
| unf_set | input | 6 | Command underflow set pulses |
| tor_set | input | 6 | Trigger overrun set pulses |
| fill_ack | input | 6 | DMA acknowledge for fill requests |
| drain_ack | input | 6 | DMA acknowledge for drain requests |
| fill_irq | output | 6 | Fill interrupt requests |
| fill_dma | output | 6 | Fill DMA requests |
| drain_irq | output | 6 | Drain interrupt requests |
| drain_dma | output | 6 | Drain DMA requests |
| ovf_irq | output | 6 | Per-pair overflow interrupts |
| err_irq | output | 1 | Combined error interrupt |

## Verification
Random sequences mix sparse set pulses, acknowledges and register writes with random control values. This covers all four enable/select combinations on both routing paths, so a swapped select polarity or a missing enable gate shows up on the wrong output line. Directed cases put a set and a write-one clear in the same cycle, and a set and an acknowledge in the same cycle, to check the priority between them. Other directed cases write 0 to a set flag, write all ones to a control register to expose the reserved bits, and use out-of-range indices. Each of these separates a correct design from one that clears on zero or stores reserved bits.

// File: rtl/fifo_req_router.sv
module fifo_req_router #(
  parameter int NPAIR = 6,
  parameter int IW    = 3,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_ctrl,
  input  logic [IW-1:0]    reg_idx,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NPAIR-1:0] fill_set,
  input  logic [NPAIR-1:0] drain_set,
  input  logic [NPAIR-1:0] ovf_set,
  input  logic [NPAIR-1:0] unf_set,
  input  logic [NPAIR-1:0] tor_set,
  input  logic [NPAIR-1:0] fill_ack,
  input  logic [NPAIR-1:0] drain_ack,
  output logic [NPAIR-1:0] fill_irq,
  output logic [NPAIR-1:0] fill_dma,
  output logic [NPAIR-1:0] drain_irq,
  output logic [NPAIR-1:0] drain_dma,
  output logic [NPAIR-1:0] ovf_irq,
  output logic             err_irq
);
  localparam int NF = 5;
  localparam int F_FILL = 0, F_DRN = 1, F_OVF = 2, F_UNF = 3, F_TOR = 4;
  localparam int C_DSEL = 0, C_DEN = 1, C_OEN = 3, C_FSEL = 8, C_FEN = 9, C_TEN = 10, C_UEN = 11;
  localparam logic [DW-1:0] CMASK = DW'((1 << C_DSEL) | (1 << C_DEN) | (1 << C_OEN) |
                                        (1 << C_FSEL) | (1 << C_FEN) | (1 << C_TEN) | (1 << C_UEN));

  logic [NPAIR-1:0][NF-1:0] flg_q;
  logic [NPAIR-1:0][DW-1:0] ctl_q;
  logic [NPAIR-1:0]         err_d;

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NPAIR; i++)
      if (reg_idx == IW'(i))
        reg_rdata = reg_ctrl ? ctl_q[i] : DW'(flg_q[i]);
  end

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    logic          wr_f, wr_c;
    logic [NF-1:0] clr, setv, flg_d;
    logic [DW-1:0] ctl_d;

    assign wr_f  = reg_wr && !reg_ctrl && reg_idx == IW'(i);
    assign wr_c  = reg_wr &&  reg_ctrl && reg_idx == IW'(i);
    assign clr   = (wr_f ? reg_wdata[NF-1:0] : '0)
                 | NF'({drain_ack[i], fill_ack[i]});
    assign setv  = {tor_set[i], unf_set[i], ovf_set[i], drain_set[i], fill_set[i]};
    assign flg_d = (flg_q[i] & ~clr) | setv;
    assign ctl_d = wr_c ? (reg_wdata & CMASK) : ctl_q[i];
    assign err_d[i] = (flg_d[F_OVF] & ctl_d[C_OEN]) | (flg_d[F_UNF] & ctl_d[C_UEN])
                    | (flg_d[F_TOR] & ctl_d[C_TEN]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flg_q[i]     <= '0;
        ctl_q[i]     <= '0;
        fill_irq[i]  <= 1'b0;
        fill_dma[i]  <= 1'b0;
        drain_irq[i] <= 1'b0;
        drain_dma[i] <= 1'b0;
        ovf_irq[i]   <= 1'b0;
      end else begin
        flg_q[i]     <= flg_d;
        ctl_q[i]     <= ctl_d;
        fill_irq[i]  <= flg_d[F_FILL] & ctl_d[C_FEN] & ~ctl_d[C_FSEL];
        fill_dma[i]  <= flg_d[F_FILL] & ctl_d[C_FEN] &  ctl_d[C_FSEL];
        drain_irq[i] <= flg_d[F_DRN]  & ctl_d[C_DEN] & ~ctl_d[C_DSEL];
        drain_dma[i] <= flg_d[F_DRN]  & ctl_d[C_DEN] &  ctl_d[C_DSEL];
        ovf_irq[i]   <= flg_d[F_OVF]  & ctl_d[C_OEN];
      end
    end

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      fill_set[i] |=> flg_q[i][F_FILL]); // R2
    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      flg_q[i][F_OVF] && !(wr_f && reg_wdata[F_OVF]) |=> flg_q[i][F_OVF]); // R2
    AST_ACK_DROPS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      fill_ack[i] && !fill_set[i] |=> !fill_dma[i] && !fill_irq[i]); // R8
    AST_ACK_DROPS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      drain_ack[i] && !drain_set[i] |=> !drain_dma[i] && !drain_irq[i]); // R8
    AST_OVF_REACHES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_set[i] && ctl_q[i][C_OEN] && !wr_c |=> err_irq && ovf_irq[i]); // R6
    AST_NO_FILL_CTRL_DROP_IN_DMA: assert property (@(posedge clk) disable iff (!rst_n)
      wr_c && fill_dma[i] |-> reg_wdata[C_FEN] && reg_wdata[C_FSEL]); // R9
    AST_NO_DRAIN_CTRL_DROP_IN_DMA: assert property (@(posedge clk) disable iff (!rst_n)
      wr_c && drain_dma[i] |-> reg_wdata[C_DEN] && reg_wdata[C_DSEL]); // R9
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_irq <= 1'b0;
    else        err_irq <= |err_d;
  end
endmodule

// File: tb/test_fifo_req_router.sv
module test_fifo_req_router;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;
  localparam logic [15:0] CMASK = 16'h0F0B;

  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0, reg_ctrl = 0;
  logic [2:0]  reg_idx = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [N-1:0] fill_set = 0, drain_set = 0, ovf_set = 0, unf_set = 0, tor_set = 0;
  logic [N-1:0] fill_ack = 0, drain_ack = 0;
  logic [N-1:0] fill_irq, fill_dma, drain_irq, drain_dma, ovf_irq;
  logic        err_irq;

  int errors = 0, checks = 0;
  logic [4:0]  mf [N];
  logic [15:0] mc [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_req_router i_fifo_req_router (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ctrl(reg_ctrl), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fill_set(fill_set), .drain_set(drain_set),
    .ovf_set(ovf_set), .unf_set(unf_set), .tor_set(tor_set), .fill_ack(fill_ack),
    .drain_ack(drain_ack), .fill_irq(fill_irq), .fill_dma(fill_dma), .drain_irq(drain_irq),
    .drain_dma(drain_dma), .ovf_irq(ovf_irq), .err_irq(err_irq));

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] e_fill(input bit dma);
    for (int i = 0; i < N; i++) e_fill[i] = mf[i][0] & mc[i][9] & (mc[i][8] == dma);
  endfunction
  function automatic logic [N-1:0] e_drain(input bit dma);
    for (int i = 0; i < N; i++) e_drain[i] = mf[i][1] & mc[i][1] & (mc[i][0] == dma);
  endfunction
  function automatic logic [N-1:0] e_ovf();
    for (int i = 0; i < N; i++) e_ovf[i] = mf[i][2] & mc[i][3];
  endfunction
  function automatic logic e_err();
    e_err = 0;
    for (int i = 0; i < N; i++)
      e_err |= (mf[i][2] & mc[i][3]) | (mf[i][3] & mc[i][11]) | (mf[i][4] & mc[i][10]);
  endfunction
  function automatic logic [15:0] e_read(input logic c, input logic [2:0] ix);
    if (ix >= 3'(N)) return 16'h0;
    return c ? mc[ix] : {11'h0, mf[ix]};
  endfunction

  task automatic check_outs();
    chk("R3 fill_irq", 32'(fill_irq), 32'(e_fill(0)));
    chk("R3 fill_dma", 32'(fill_dma), 32'(e_fill(1)));
    chk("R4 drain_irq", 32'(drain_irq), 32'(e_drain(0)));
    chk("R4 drain_dma", 32'(drain_dma), 32'(e_drain(1)));
    chk("R5 ovf_irq", 32'(ovf_irq), 32'(e_ovf()));
    chk("R6 err_irq", 32'(err_irq), 32'(e_err()));
  endtask

  // Inputs are driven just after a falling edge; outputs checked at the next falling edge (R10).
  task automatic step();
    #1;
    chk("R7 read", 32'(reg_rdata), 32'(e_read(reg_ctrl, reg_idx)));
    for (int i = 0; i < N; i++) begin
      logic [4:0] clr;
      clr = {3'b0, drain_ack[i], fill_ack[i]};
      if (reg_wr && !reg_ctrl && reg_idx == 3'(i)) clr |= reg_wdata[4:0];
      mf[i] = (mf[i] & ~clr) | {tor_set[i], unf_set[i], ovf_set[i], drain_set[i], fill_set[i]};
      if (reg_wr && reg_ctrl && reg_idx == 3'(i)) mc[i] = reg_wdata & CMASK;
    end
    @(negedge clk);
    check_outs();
    reg_wr = 0; fill_set = 0; drain_set = 0; ovf_set = 0; unf_set = 0; tor_set = 0;
    fill_ack = 0; drain_ack = 0;
  endtask

  task automatic wr(input logic c, input logic [2:0] ix, input logic [15:0] d);
    reg_wr = 1; reg_ctrl = c; reg_idx = ix; reg_wdata = d;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < N; i++) begin mf[i] = 0; mc[i] = 0; end
    repeat (3) @(negedge clk);
    check_outs(); // R1
    for (int i = 0; i < N; i++) begin
      reg_idx = 3'(i); reg_ctrl = 1; #1 chk("R1 ctrl read", 32'(reg_rdata), 0);
      reg_ctrl = 0; #1 chk("R1 flag read", 32'(reg_rdata), 0);
    end
    rst_n = 1;
    @(negedge clk);

    // R7: reserved bits read 0, out-of-range index ignored
    wr(1, 2, 16'hFFFF); step();
    reg_ctrl = 1; reg_idx = 2; #1 chk("R7 ctrl mask", 32'(reg_rdata), 32'h0F0B);
    wr(1, 7, 16'hFFFF); step();
    reg_ctrl = 1; reg_idx = 7; #1 chk("R7 idx7 reads 0", 32'(reg_rdata), 0);

    // R3: fill routed to interrupt (select 0)
    wr(1, 0, 16'h0200); step();
    fill_set[0] = 1; step();
    chk("R3 fill irq path", 32'(fill_irq[0]), 1);
    // R2: writing 0 keeps the flag, set beats clear
    wr(0, 0, 16'h0000); step();
    reg_ctrl = 0; reg_idx = 0; #1 chk("R2 write0 keeps", 32'(reg_rdata[0]), 1);
    wr(0, 0, 16'h0001); fill_set[0] = 1; step();
    reg_ctrl = 0; reg_idx = 0; #1 chk("R2 set wins", 32'(reg_rdata[0]), 1);
    wr(0, 0, 16'h0001); step();
    chk("R2 w1c clears", 32'(fill_irq[0]), 0);

    // R8: fill DMA request dropped by acknowledge; set wins over ack
    wr(1, 1, 16'h0300); step();
    fill_set[1] = 1; step();
    chk("R8 dma up", 32'(fill_dma[1]), 1);
    fill_ack[1] = 1; fill_set[1] = 1; step();
    chk("R8 set beats ack", 32'(fill_dma[1]), 1);
    fill_ack[1] = 1; step();
    chk("R8 ack drops req", 32'(fill_dma[1]), 0);

    // R4 / R8: drain DMA
    wr(1, 3, 16'h0003); step();
    drain_set[3] = 1; step();
    chk("R4 drain dma", 32'(drain_dma[3]), 1);
    drain_ack[3] = 1; step();
    chk("R8 drain ack", 32'(drain_dma[3]), 0);

    // R6: underflow and trigger overrun feed the combined interrupt
    wr(1, 4, 16'h0800); step();
    unf_set[4] = 1; step();
    chk("R6 underflow err", 32'(err_irq), 1);
    wr(0, 4, 16'h0008); step();
    chk("R6 err clears", 32'(err_irq), 0);

    // Random mix
    for (int k = 0; k < 3000; k++) begin
      fill_set  = N'(($urandom % 8 == 0) ? $urandom : 0);
      drain_set = N'(($urandom % 8 == 0) ? $urandom : 0);
      ovf_set   = N'(($urandom % 16 == 0) ? $urandom : 0);
      unf_set   = N'(($urandom % 16 == 0) ? $urandom : 0);
      tor_set   = N'(($urandom % 16 == 0) ? $urandom : 0);
      fill_ack  = N'(fill_dma & N'($urandom));
      drain_ack = N'(drain_dma & N'($urandom));
      reg_ctrl  = 1'($urandom);
      reg_idx   = 3'($urandom);
      reg_wdata = 16'($urandom);
      reg_wr    = ($urandom % 4 == 0);
      if (reg_wr && reg_ctrl && reg_idx < 3'(N)) begin
        if (fill_dma[reg_idx])  reg_wdata[9:8] = 2'b11;   // R9 legal usage only
        if (drain_dma[reg_idx]) reg_wdata[1:0] = 2'b11;
      end
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule